// File: doc/BRIEF.md
# Channel Transaction Handshake Controller

This block sits between the transport side of one data channel and a user core. Each transfer is a framed transaction. A request and acknowledge handshake carries a word count, a destination offset and a group-end flag. A first-word-fall-through data port carries the payload. The block adds this framing around the data instead of presenting a bare FIFO.

In the receive direction the transport side offers a header (count, offset, group-end flag) and then a stream of data beats. The block accepts the header and raises a request towards the user core with the captured fields. It passes no data until the core pulses acknowledge. It then streams beats until the announced word count is reached.

In the send direction the user core raises a request with its own header fields. The block acknowledges once and captures the fields in the acknowledge cycle. It then drains beats from the core to the transport side until the captured count is used up. A data beat moves only in a cycle where its valid and its consume strobe are both high. The beat width is 32, 64 or 128 bits, so one beat carries 1, 2 or 4 words of 32 bits. Both directions share one clock and one synchronous active-high reset.

Top module: `chan_hs_ctrl`

## Requirements
- R1: After reset, `rx_req`, `rx_data_valid`, `in_ready`, `tx_ack`, `tx_data_ren`, `out_active` and `out_valid` are low and `in_hdr_ready` is high.
- R2: A header is taken in a cycle where `in_hdr_valid` and `in_hdr_ready` are both high. From the next cycle `rx_req` is high, `in_hdr_ready` is low, and `rx_len`, `rx_off` and `rx_last` show the taken values unchanged until `rx_req` falls.
- R3: While `rx_req` is high and no acknowledge has been given, `rx_data_valid` and `in_ready` stay low whatever `in_valid` and `rx_data_ren` do, so no beat moves.
- R4: From the cycle after `rx_ack` is sampled high, `rx_data_valid` follows `in_valid`, `in_ready` follows `rx_data_ren` and `rx_data` equals `in_data`. A beat moves only when valid and consume are both high.
- R5: `rx_req` falls in the cycle after the beat that completes the word count. Later inbound beats are not consumed. With a count of 0, `rx_req` falls in the cycle after the acknowledge.
- R6: `tx_ack` is high for exactly one cycle. That cycle is the one after `tx_req` is first sampled high while no send transaction is active.
- R7: `tx_len`, `tx_off` and `tx_last` are captured in the `tx_ack` cycle and shown on `out_len`, `out_off` and `out_last`. They stay stable while `out_active` is high, and later changes on the inputs have no effect on them.
- R8: While `out_active` is high, `out_valid` follows `tx_data_valid`, `tx_data_ren` follows `out_ready` and `out_data` equals `tx_data`.
- R9: `out_active` falls in the cycle after the beat that completes the count, or right after the acknowledge for a count of 0. No `tx_ack` is given while `out_active` is high, even with `tx_req` held high.
- R10: Each beat counts min(remaining, words per beat) words, so a final partial beat is padded. For example, a count of 3 on a 64-bit port takes 2 beats and a count of 5 takes 3 beats.
- R11: A reset during any transaction returns both directions to idle and clears `rx_len`, `rx_off`, `rx_last`, `out_len`, `out_off` and `out_last` to 0.
- R12: `DATA_W` must be 32, 64 or 128, and the words per beat equal `DATA_W`/32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_hdr_valid | input | 1 | Transport offers an inbound header |
| in_hdr_ready | output | 1 | Block can take a header |
| in_len | input | 32 | Inbound word count |
| in_off | input | 31 | Inbound destination offset in words |
| in_last | input | 1 | Inbound group-end flag |
| in_data | input | DATA_W | Inbound data beat |
| in_valid | input | 1 | Inbound beat valid |
| in_ready | output | 1 | Inbound beat consumed |
| rx_req | output | 1 | Receive transaction announced to user core |
| rx_ack | input | 1 | User core acknowledges the receive transaction |
| rx_len | output | 32 | Receive word count |
| rx_off | output | 31 | Receive offset in words |
| rx_last | output | 1 | Receive group-end flag |
| rx_data | output | DATA_W | Receive data beat |
| rx_data_valid | output | 1 | Receive beat valid |
| rx_data_ren | input | 1 | User core consumes receive beat |
| tx_req | input | 1 | User core requests a send transaction |
| tx_ack | output | 1 | Send acknowledge pulse |
| tx_len | input | 32 | Send word count |
| tx_off | input | 31 | Send offset in words |
| tx_last | input | 1 | Send group-end flag |
| tx_data | input | DATA_W | Send data beat |
| tx_data_valid | input | 1 | Send beat valid |
| tx_data_ren | output | 1 | Block consumes send beat |
| out_active | output | 1 | Send transaction being drained |
| out_len | output | 32 | Captured send word count |
| out_off | output | 31 | Captured send offset |
| out_last | output | 1 | Captured send group-end flag |
| out_data | output | DATA_W | Outbound data beat |
| out_valid | output | 1 | Outbound beat valid |
| out_ready | input | 1 | Transport takes outbound beat |

## Verification
A word counter that is off by one shows up in the cycle after the final beat. The request or the active flag then either stays high while further beats are consumed, or falls a beat early, and the bench watches that cycle for every count it uses. A wrong handshake state appears at once as data passing before acknowledge, as a second acknowledge during a drain, or as an acknowledge that comes a cycle late. Corrupted captured fields appear on the header outputs in the first cycle of the transaction and persist until it ends.

// File: rtl/chan_hs_pkg.sv
package chan_hs_pkg;
    localparam int LEN_W  = 32;
    localparam int OFF_W  = 31;
    localparam int WORD_W = 32;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [OFF_W-1:0] off;
        logic             last;
    } xfer_meta_t;

    typedef enum logic [1:0] {RX_IDLE, RX_OFFER, RX_STREAM} rx_state_e;
    typedef enum logic [1:0] {TX_IDLE, TX_ACK, TX_DRAIN} tx_state_e;

    function automatic int unsigned words_per_beat(input int unsigned dw);
        return dw / WORD_W;
    endfunction

    function automatic bit width_ok(input int unsigned dw);
        return (dw == 32) || (dw == 64) || (dw == 128);
    endfunction
endpackage

// File: rtl/word_tracker.sv
module word_tracker
    import chan_hs_pkg::*;
#(
    parameter int unsigned WPB = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic             beat,
    output logic             final_beat,
    output logic             empty
);
    localparam logic [LEN_W-1:0] WPB_L = LEN_W'(WPB);

    logic [LEN_W-1:0] remain_q;
    logic [LEN_W-1:0] remain_after;

    generate
        if (WPB == 1) begin : g_single
            assign remain_after = remain_q - 1'b1;
            assign final_beat   = (remain_q == WPB_L);
        end else begin : g_multi
            assign remain_after = (remain_q <= WPB_L) ? '0 : remain_q - WPB_L;
            assign final_beat   = (remain_q <= WPB_L);
        end
    endgenerate

    assign empty = (remain_q == '0);

    always_ff @(posedge clk) begin
        if (rst)       remain_q <= '0;
        else if (load) remain_q <= load_len;
        else if (beat) remain_q <= remain_after;
    end

    // R10: a beat is only ever taken while words remain
    p_beat_has_words_r10: assert property (@(posedge clk) disable iff (rst)
        beat |-> !empty);
endmodule

// File: rtl/rx_ctrl.sv
module rx_ctrl
    import chan_hs_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned WPB    = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_hdr_valid,
    output logic              in_hdr_ready,
    input  xfer_meta_t        in_meta,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              rx_req,
    input  logic              rx_ack,
    output xfer_meta_t        rx_meta,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_data_valid,
    input  logic              rx_data_ren
);
    rx_state_e  state_q, state_d;
    xfer_meta_t meta_q;
    logic       take_hdr, streaming, beat, final_beat, empty;

    assign in_hdr_ready  = (state_q == RX_IDLE);
    assign take_hdr      = in_hdr_ready && in_hdr_valid;
    assign streaming     = (state_q == RX_STREAM);
    assign rx_req        = (state_q != RX_IDLE);
    assign rx_meta       = meta_q;
    assign rx_data       = in_data;
    assign rx_data_valid = streaming && in_valid;
    assign in_ready      = streaming && rx_data_ren;
    assign beat          = streaming && in_valid && rx_data_ren;

    word_tracker #(.WPB(WPB)) u_cnt (
        .clk(clk), .rst(rst), .load(take_hdr), .load_len(in_meta.len),
        .beat(beat), .final_beat(final_beat), .empty(empty)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:   if (take_hdr) state_d = RX_OFFER;
            RX_OFFER:  if (rx_ack) state_d = empty ? RX_IDLE : RX_STREAM;
            RX_STREAM: if (beat && final_beat) state_d = RX_IDLE;
            default:   state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_IDLE;
            meta_q  <= '0;
        end else begin
            state_q <= state_d;
            if (take_hdr) meta_q <= in_meta;
        end
    end

    p_rx_valid_needs_req_r3: assert property (@(posedge clk) disable iff (rst)
        rx_data_valid |-> rx_req);
    p_in_ready_needs_req_r4: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> rx_req);
    p_rx_meta_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (rx_req && $past(rx_req)) |-> (rx_meta == $past(rx_meta)));
endmodule

// File: rtl/tx_ctrl.sv
module tx_ctrl
    import chan_hs_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned WPB    = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_req,
    output logic              tx_ack,
    input  xfer_meta_t        tx_meta,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_data_valid,
    output logic              tx_data_ren,
    output logic              out_active,
    output xfer_meta_t        out_meta,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready
);
    tx_state_e  state_q, state_d;
    xfer_meta_t meta_q;
    logic       beat, final_beat, empty;

    assign tx_ack      = (state_q == TX_ACK);
    assign out_active  = (state_q == TX_DRAIN);
    assign out_meta    = meta_q;
    assign out_data    = tx_data;
    assign out_valid   = out_active && tx_data_valid;
    assign tx_data_ren = out_active && out_ready;
    assign beat        = out_active && tx_data_valid && out_ready;

    word_tracker #(.WPB(WPB)) u_cnt (
        .clk(clk), .rst(rst), .load(tx_ack), .load_len(tx_meta.len),
        .beat(beat), .final_beat(final_beat), .empty(empty)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (tx_req) state_d = TX_ACK;
            TX_ACK:   state_d = (tx_meta.len == '0) ? TX_IDLE : TX_DRAIN;
            TX_DRAIN: if (beat && final_beat) state_d = TX_IDLE;
            default:  state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TX_IDLE;
            meta_q  <= '0;
        end else begin
            state_q <= state_d;
            if (tx_ack) meta_q <= tx_meta;
        end
    end

    p_ack_single_r6: assert property (@(posedge clk) disable iff (rst)
        tx_ack |=> !tx_ack);
    p_ack_after_req_r6: assert property (@(posedge clk) disable iff (rst)
        tx_ack |-> $past(tx_req));
    p_no_ack_while_active_r9: assert property (@(posedge clk) disable iff (rst)
        out_active |-> !tx_ack);
    p_active_has_words_r9: assert property (@(posedge clk) disable iff (rst)
        out_active |-> !empty);
    p_out_meta_stable_r7: assert property (@(posedge clk) disable iff (rst)
        (out_active && $past(out_active)) |-> (out_meta == $past(out_meta)));
    p_out_valid_active_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_active);
endmodule

// File: rtl/chan_hs_ctrl.sv
module chan_hs_ctrl
    import chan_hs_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_hdr_valid,
    output logic              in_hdr_ready,
    input  logic [31:0]       in_len,
    input  logic [30:0]       in_off,
    input  logic              in_last,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              rx_req,
    input  logic              rx_ack,
    output logic [31:0]       rx_len,
    output logic [30:0]       rx_off,
    output logic              rx_last,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_data_valid,
    input  logic              rx_data_ren,
    input  logic              tx_req,
    output logic              tx_ack,
    input  logic [31:0]       tx_len,
    input  logic [30:0]       tx_off,
    input  logic              tx_last,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_data_valid,
    output logic              tx_data_ren,
    output logic              out_active,
    output logic [31:0]       out_len,
    output logic [30:0]       out_off,
    output logic              out_last,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready
);
    localparam int unsigned WPB = words_per_beat(DATA_W);

    initial begin
        p_width_legal_r12: assert (width_ok(DATA_W))
            else $error("R12: DATA_W %0d not supported", DATA_W);
    end

    xfer_meta_t in_meta, rx_meta, tx_meta, out_meta;

    assign in_meta = '{len: in_len, off: in_off, last: in_last};
    assign tx_meta = '{len: tx_len, off: tx_off, last: tx_last};
    assign rx_len  = rx_meta.len;
    assign rx_off  = rx_meta.off;
    assign rx_last = rx_meta.last;
    assign out_len  = out_meta.len;
    assign out_off  = out_meta.off;
    assign out_last = out_meta.last;

    rx_ctrl #(.DATA_W(DATA_W), .WPB(WPB)) u_rx (
        .clk(clk), .rst(rst),
        .in_hdr_valid(in_hdr_valid), .in_hdr_ready(in_hdr_ready), .in_meta(in_meta),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .rx_req(rx_req), .rx_ack(rx_ack), .rx_meta(rx_meta),
        .rx_data(rx_data), .rx_data_valid(rx_data_valid), .rx_data_ren(rx_data_ren)
    );

    tx_ctrl #(.DATA_W(DATA_W), .WPB(WPB)) u_tx (
        .clk(clk), .rst(rst),
        .tx_req(tx_req), .tx_ack(tx_ack), .tx_meta(tx_meta),
        .tx_data(tx_data), .tx_data_valid(tx_data_valid), .tx_data_ren(tx_data_ren),
        .out_active(out_active), .out_meta(out_meta),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
    );
endmodule

// File: tb/chan_hs_ctrl_tb_top.sv
`timescale 1ns/100ps
module chan_hs_ctrl_tb_top;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_hdr_valid, in_hdr_ready, in_last, in_valid, in_ready;
    logic [31:0]   in_len;
    logic [30:0]   in_off;
    logic [DW-1:0] in_data;
    logic          rx_req, rx_ack, rx_last, rx_data_valid, rx_data_ren;
    logic [31:0]   rx_len;
    logic [30:0]   rx_off;
    logic [DW-1:0] rx_data;
    logic          tx_req, tx_ack, tx_last, tx_data_valid, tx_data_ren;
    logic [31:0]   tx_len;
    logic [30:0]   tx_off;
    logic [DW-1:0] tx_data;
    logic          out_active, out_last, out_valid, out_ready;
    logic [31:0]   out_len;
    logic [30:0]   out_off;
    logic [DW-1:0] out_data;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    chan_hs_ctrl #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst),
        .in_hdr_valid(in_hdr_valid), .in_hdr_ready(in_hdr_ready),
        .in_len(in_len), .in_off(in_off), .in_last(in_last),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .rx_req(rx_req), .rx_ack(rx_ack), .rx_len(rx_len), .rx_off(rx_off),
        .rx_last(rx_last), .rx_data(rx_data), .rx_data_valid(rx_data_valid),
        .rx_data_ren(rx_data_ren),
        .tx_req(tx_req), .tx_ack(tx_ack), .tx_len(tx_len), .tx_off(tx_off),
        .tx_last(tx_last), .tx_data(tx_data), .tx_data_valid(tx_data_valid),
        .tx_data_ren(tx_data_ren),
        .out_active(out_active), .out_len(out_len), .out_off(out_off),
        .out_last(out_last), .out_data(out_data), .out_valid(out_valid),
        .out_ready(out_ready)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        in_hdr_valid = 0; in_len = 0; in_off = 0; in_last = 0;
        in_data = 0; in_valid = 0; rx_ack = 0; rx_data_ren = 0;
        tx_req = 0; tx_len = 0; tx_off = 0; tx_last = 0;
        tx_data = 0; tx_data_valid = 0; out_ready = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1; idle_inputs();
        @(negedge clk); @(negedge clk); rst = 0;
    endtask

    // offer a header; returns at the negedge after it was taken
    task automatic rx_offer(input logic [31:0] len, input logic [30:0] off, input logic lst);
        in_hdr_valid = 1; in_len = len; in_off = off; in_last = lst;
        @(negedge clk);
        in_hdr_valid = 0;
    endtask

    task automatic rx_give_ack();
        rx_ack = 1; @(negedge clk); rx_ack = 0;
    endtask

    task automatic t_reset();
        do_reset(); #1;
        check("R1", "rx_req", rx_req, 0);
        check("R1", "rx_data_valid", rx_data_valid, 0);
        check("R1", "in_ready", in_ready, 0);
        check("R1", "tx_ack", tx_ack, 0);
        check("R1", "tx_data_ren", tx_data_ren, 0);
        check("R1", "out_active", out_active, 0);
        check("R1", "out_valid", out_valid, 0);
        check("R1", "in_hdr_ready", in_hdr_ready, 1);
    endtask

    task automatic t_rx_basic();
        rx_offer(32'd4, 31'd7, 1'b1); #1;
        check("R2", "rx_req", rx_req, 1);
        check("R2", "rx_len", rx_len, 4);
        check("R2", "rx_off", rx_off, 7);
        check("R2", "rx_last", rx_last, 1);
        check("R2", "in_hdr_ready", in_hdr_ready, 0);
        in_valid = 1; in_data = 64'hA1; rx_data_ren = 1; #1;
        check("R3", "rx_data_valid before ack", rx_data_valid, 0);
        check("R3", "in_ready before ack", in_ready, 0);
        @(negedge clk); #1;
        check("R3", "rx_req still waiting", rx_req, 1);
        rx_give_ack(); #1;
        check("R4", "rx_data_valid", rx_data_valid, 1);
        check("R4", "rx_data", rx_data, 64'hA1);
        check("R4", "in_ready", in_ready, 1);
        check("R2", "rx_len held", rx_len, 4);
        @(negedge clk); in_data = 64'hB2; #1;
        check("R4", "second beat", rx_data, 64'hB2);
        @(negedge clk); #1;
        check("R5", "rx_req after count", rx_req, 0);
        check("R5", "in_ready after count", in_ready, 0);
        check("R5", "in_hdr_ready after count", in_hdr_ready, 1);
        in_valid = 0; rx_data_ren = 0;
    endtask

    task automatic t_rx_pad();
        rx_offer(32'd3, 31'd0, 1'b0);
        check("R2", "rx_last low", rx_last, 0);
        rx_give_ack();
        in_valid = 1; rx_data_ren = 1;
        @(negedge clk); #1;
        check("R10", "rx_req after first of 3 words", rx_req, 1);
        in_valid = 0; #1;
        check("R4", "no valid while stalled", rx_data_valid, 0);
        @(negedge clk); #1;
        check("R4", "stall does not count", rx_req, 1);
        in_valid = 1;
        @(negedge clk); #1;
        check("R10", "3 words take 2 beats", rx_req, 0);
        in_valid = 0; rx_data_ren = 0;
        rx_offer(32'd0, 31'd2, 1'b1);
        rx_give_ack(); #1;
        check("R5", "zero count ends after ack", rx_req, 0);
    endtask

    task automatic t_tx_basic();
        tx_req = 1; tx_len = 32'd4; tx_off = 31'd9; tx_last = 0;
        @(negedge clk); #1;
        check("R6", "tx_ack one cycle after req", tx_ack, 1);
        check("R9", "not active during ack", out_active, 0);
        @(negedge clk); #1;
        check("R6", "tx_ack single pulse", tx_ack, 0);
        check("R7", "out_active", out_active, 1);
        check("R7", "out_len", out_len, 4);
        check("R7", "out_off", out_off, 9);
        check("R7", "out_last", out_last, 0);
        tx_len = 32'd99; tx_off = 31'd1; tx_last = 1;
        tx_data_valid = 1; tx_data = 64'hC3; out_ready = 0; #1;
        check("R8", "out_valid", out_valid, 1);
        check("R8", "tx_data_ren while not ready", tx_data_ren, 0);
        @(negedge clk); out_ready = 1; #1;
        check("R8", "tx_data_ren", tx_data_ren, 1);
        check("R8", "out_data", out_data, 64'hC3);
        check("R7", "out_len unaffected", out_len, 4);
        check("R7", "out_last unaffected", out_last, 0);
        @(negedge clk); tx_data = 64'hD4; #1;
        check("R9", "active before final beat", out_active, 1);
        @(negedge clk); tx_req = 0; #1;
        check("R9", "inactive after final beat", out_active, 0);
        check("R8", "no consume after final", tx_data_ren, 0);
        tx_data_valid = 0; out_ready = 0;
        @(negedge clk); #1;
        check("R6", "no ack without req", tx_ack, 0);
    endtask

    task automatic t_tx_hold();
        int acks = 0;
        tx_req = 1; tx_len = 32'd2; tx_off = 0; tx_last = 1;
        @(negedge clk); @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            #1; if (tx_ack) acks++;
            @(negedge clk);
        end
        check("R9", "acks while held and draining", acks, 0);
        tx_data_valid = 1; out_ready = 1;
        @(negedge clk); tx_req = 0; #1;
        check("R9", "one-beat drain ends", out_active, 0);
        tx_data_valid = 0; out_ready = 0;
        @(negedge clk); #1;
        check("R9", "no retrigger", tx_ack, 0);
        tx_req = 1; tx_len = 0;
        @(negedge clk); #1;
        check("R6", "zero count ack", tx_ack, 1);
        tx_req = 0;
        @(negedge clk); #1;
        check("R9", "zero count not active", out_active, 0);
    endtask

    task automatic t_tx_pad();
        int beats = 0;
        tx_req = 1; tx_len = 32'd5; tx_off = 31'd3; tx_last = 1;
        @(negedge clk); @(negedge clk);
        tx_data_valid = 1; out_ready = 1;
        while (out_active && beats < 8) begin
            @(negedge clk); beats++;
        end
        tx_req = 0; tx_data_valid = 0; out_ready = 0;
        check("R10", "5 words take 3 beats", beats, 3);
        check("R12", "64-bit beat holds 2 words", out_active, 0);
    endtask

    task automatic t_reset_mid();
        rx_offer(32'd6, 31'd5, 1'b1);
        tx_req = 1; tx_len = 32'd8; tx_off = 31'd4; tx_last = 1;
        @(negedge clk); @(negedge clk); #1;
        check("R11", "tx active before reset", out_active, 1);
        rst = 1; tx_req = 0;
        @(negedge clk); rst = 0; #1;
        check("R11", "rx_req cleared", rx_req, 0);
        check("R11", "rx_len cleared", rx_len, 0);
        check("R11", "rx_last cleared", rx_last, 0);
        check("R11", "out_active cleared", out_active, 0);
        check("R11", "out_len cleared", out_len, 0);
        check("R11", "out_off cleared", out_off, 0);
        check("R11", "in_hdr_ready", in_hdr_ready, 1);
        check("R11", "tx_ack", tx_ack, 0);
    endtask

    initial begin
        rst = 1; idle_inputs();
        t_reset();
        t_rx_basic();
        t_rx_pad();
        t_tx_basic();
        t_tx_hold();
        t_tx_pad();
        t_reset_mid();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule